// File: doc/BRIEF.md
# Codec Register Bridge

This block sits between a 32-bit host bus and a small file of 8-bit codec control registers. The host never addresses the codec registers directly. It writes a command word at host offset 0x00 that names an internal address and, when bit 16 is set, a byte to store. It then either polls the busy flag until the store has committed, or reads the selected byte back from the data-out word at host offset 0x04 once the read delay has passed.

The block is built around a sequencer with three states:

- `ST_IDLE`: waits for a command.
- `ST_WR_BUSY`: counts down the write-commit delay.
- `ST_RD_SETTLE`: counts down the read settle delay.

The transitions are:

- `ST_IDLE` to `ST_WR_BUSY` on a command with bit 16 set (start-write).
- `ST_IDLE` to `ST_RD_SETTLE` on a command with bit 16 clear (start-read).
- `ST_WR_BUSY` to `ST_IDLE` when the count expires. The byte is committed on that edge (commit).
- `ST_RD_SETTLE` to `ST_IDLE` when the count expires. The data-out byte is loaded on that edge (load).
- `ST_RD_SETTLE` to `ST_WR_BUSY` or back to `ST_RD_SETTLE` when a new command arrives during the settle. The new command replaces the pending read (preempt).

The internal map has 36 byte registers. Address 0 is a read-only status byte. Addresses 5 and 28 are holes.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset, host offset 0x00 and offset 0x04 both read 0x00000000 while the interrupt input is low.
- R2: Host offset 0x00 reads back the last accepted command. Bit 16 is busy, bits 14:8 are the internal address, bits 7:0 are the write byte, and all other bits are 0.
- R3: A host write at offset 0x00 with bit 16 set makes bit 16 read 1 for exactly 4 clock cycles after the write edge. The byte is stored in the addressed register on the edge where busy clears. This holds up to the last address, 35.
- R4: A command written to offset 0x00 while busy reads 1 is dropped. The latched address and data do not change, and no store is queued.
- R5: A host write at offset 0x00 with bit 16 clear selects an address for reading. Offset 0x04 bits 7:0 keep their previous value for 2 cycles after the write edge and show the addressed byte from the 3rd edge on. Bits 31:9 of offset 0x04 are 0.
- R6: Offset 0x04 bit 8 follows the codec interrupt input.
- R7: The reset contents are 0xC3 at addresses 1 and 2, 0x90 at address 3, 0x98 at address 4, and 0x00 everywhere else.
- R8: Address 0 is read-only. Stores to it leave it reading 0x00.
- R9: Addresses 5 and 28, and any address from 36 upward, ignore stores and read 0x00.
- R10: Host writes to any offset other than 0x00 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 4 | Host byte offset: 0x0 is the command word, 0x4 is the data-out word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr, combinational |
| codec_irq | input | 1 | Codec interrupt line, mirrored on data-out bit 8 |

## Verification
The bench checks the busy window edge by edge: one cycle short or one cycle long shows up as a wrong bit 16. It issues a second command in the cycle right after a store. A design that queued or accepted that command would store to the wrong register or change the latched address. It samples data-out one cycle before and in the cycle where the read settles, which catches an early load or a missing load. It stores to address 0, to both holes and to an out-of-range address, and then reads them back. A design that let those stores through would return the written bytes instead of 0x00.

// File: rtl/codec_bridge_pkg.sv
package codec_bridge_pkg;

    localparam int REG_W     = 8;
    localparam int IADDR_W   = 7;
    localparam int NUM_REGS  = 36;
    localparam int HOLE_A    = 5;
    localparam int HOLE_B    = 28;
    localparam int RO_ADDR   = 0;
    localparam int CMD_OFF   = 0;
    localparam int DOUT_OFF  = 4;
    localparam int BUSY_BIT  = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_BUSY,
        ST_RD_SETTLE
    } brg_state_t;

    function automatic logic [REG_W-1:0] reg_default(input int unsigned a);
        case (a)
            1, 2:    reg_default = 8'hC3;
            3:       reg_default = 8'h90;
            4:       reg_default = 8'h98;
            default: reg_default = 8'h00;
        endcase
    endfunction

    function automatic bit reg_is_hole(input int unsigned a);
        reg_is_hole = (a == HOLE_A) || (a == HOLE_B);
    endfunction

    function automatic bit reg_is_writable(input int unsigned a);
        reg_is_writable = !reg_is_hole(a) && (a != RO_ADDR);
    endfunction

endpackage

// File: rtl/bridge_seq.sv
module bridge_seq
    import codec_bridge_pkg::*;
#(
    parameter int WR_LAT = 4,
    parameter int RD_LAT = 3,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_is_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_data,
    output logic              commit_en,
    output logic              load_en
);

    localparam int MAX_LAT = (WR_LAT > RD_LAT) ? WR_LAT : RD_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    brg_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             cnt_zero;

    assign accept   = cmd_wr && (state != ST_WR_BUSY);
    assign cnt_zero = (cnt == '0);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nx = cmd_is_write ? ST_WR_BUSY : ST_RD_SETTLE;
            end
            ST_WR_BUSY: begin
                if (cnt_zero) state_nx = ST_IDLE;
            end
            ST_RD_SETTLE: begin
                if (accept)        state_nx = cmd_is_write ? ST_WR_BUSY : ST_RD_SETTLE;
                else if (cnt_zero) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // command latch and delay counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            lat_addr <= '0;
            lat_data <= '0;
        end else if (accept) begin
            cnt      <= cmd_is_write ? CNT_W'(WR_LAT - 1) : CNT_W'(RD_LAT - 1);
            lat_addr <= cmd_addr;
            lat_data <= cmd_data;
        end else if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        commit_en = 1'b0;
        load_en   = 1'b0;
        unique case (state)
            ST_IDLE:      ;
            ST_WR_BUSY: begin
                busy      = 1'b1;
                commit_en = cnt_zero;
            end
            ST_RD_SETTLE: load_en = cnt_zero;
            default:      ;
        endcase
    end

    // R4: a command arriving while busy leaves the latched command untouched
    a_r4_busy_drops_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> ($stable(lat_addr) && $stable(lat_data)));

    // R3: busy ends on the edge that commits the byte
    a_r3_commit_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> !busy);

    // R3: busy is entered only from a write command
    a_r3_busy_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_wr && cmd_is_write));

    // R5: a read load never overlaps a write in progress
    a_r5_load_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !busy);

endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
    import codec_bridge_pkg::*;
#(
    parameter int N_REGS = 36,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] ent [N_REGS];

    for (genvar g = 0; g < N_REGS; g++) begin : g_ent
        if (reg_is_hole(g)) begin : g_hole
            assign ent[g] = '0;
        end else if (!reg_is_writable(g)) begin : g_ro
            assign ent[g] = DATA_W'(reg_default(g));
        end else begin : g_rw
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                q <= DATA_W'(reg_default(g));
                else if (wr_en && wr_addr == ADDR_W'(g))   q <= wr_data;
            end
            assign ent[g] = q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = ent[i];
        end
    end

    // R9: holes and out-of-range addresses read as zero
    a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(HOLE_A) || rd_addr == ADDR_W'(HOLE_B) ||
         rd_addr >= ADDR_W'(N_REGS)) |-> (rd_data == '0));

    // R8: the read-only status byte never moves off its reset value
    a_r8_status_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(RO_ADDR)) |-> (rd_data == DATA_W'(reg_default(RO_ADDR))));

endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
    import codec_bridge_pkg::*;
#(
    parameter int OFF_W  = 4,
    parameter int WR_LAT = 4,
    parameter int RD_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [OFF_W-1:0] host_addr,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    input  logic             codec_irq
);

    logic               cmd_wr;
    logic               busy, commit_en, load_en;
    logic [IADDR_W-1:0] lat_addr;
    logic [REG_W-1:0]   lat_data;
    logic [REG_W-1:0]   rf_rd_data;
    logic [REG_W-1:0]   dout_q;

    assign cmd_wr = host_wr && (host_addr == OFF_W'(CMD_OFF));

    bridge_seq #(
        .WR_LAT (WR_LAT),
        .RD_LAT (RD_LAT),
        .ADDR_W (IADDR_W),
        .DATA_W (REG_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_is_write (host_wdata[BUSY_BIT]),
        .cmd_addr     (host_wdata[8 +: IADDR_W]),
        .cmd_data     (host_wdata[REG_W-1:0]),
        .busy         (busy),
        .lat_addr     (lat_addr),
        .lat_data     (lat_data),
        .commit_en    (commit_en),
        .load_en      (load_en)
    );

    codec_regfile #(
        .N_REGS (NUM_REGS),
        .ADDR_W (IADDR_W),
        .DATA_W (REG_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_en),
        .wr_addr (lat_addr),
        .wr_data (lat_data),
        .rd_addr (lat_addr),
        .rd_data (rf_rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dout_q <= '0;
        else if (load_en) dout_q <= rf_rd_data;
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == OFF_W'(CMD_OFF)) begin
            host_rdata[BUSY_BIT]          = busy;
            host_rdata[8 +: IADDR_W]      = lat_addr;
            host_rdata[REG_W-1:0]         = lat_data;
        end else if (host_addr == OFF_W'(DOUT_OFF)) begin
            host_rdata[8]                 = codec_irq;
            host_rdata[REG_W-1:0]         = dout_q;
        end
    end

    // R5: data-out holds between loads
    a_r5_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(dout_q));

    // R10: writes to other offsets never start a command
    a_r10_other_off: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr != OFF_W'(CMD_OFF) && !busy && !load_en)
            |=> ($stable(lat_addr) && $stable(dout_q)));

endmodule

// File: tb/sim_codec_reg_bridge.sv
`timescale 1ns/1ps
module sim_codec_reg_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = 4'h4;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        codec_irq = 1'b0;

    int ncheck = 0;
    int nfail  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    event       smp;

    always #2.5 clk = ~clk;

    codec_reg_bridge u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .codec_irq  (codec_irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        ncheck++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic peek(input logic [3:0] off, output logic [31:0] v);
        host_addr = off;
        #0.1;
        v = host_rdata;
    endtask

    task automatic cmd(input logic [31:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 4'h0; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    function automatic logic [31:0] wcmd(input logic [6:0] a, input logic [7:0] d);
        return {15'b0, 1'b1, 1'b0, a, d};
    endfunction

    function automatic logic [31:0] rcmd(input logic [6:0] a);
        return {16'b0, 1'b0, a, 8'h00};
    endfunction

    task automatic wr_int(input logic [6:0] a, input logic [7:0] d);
        cmd(wcmd(a, d));
        repeat (4) @(negedge clk);
    endtask

    // driver: issue a read, push the expected byte, signal the monitor at settle time
    task automatic rd_int(input logic [6:0] a, input logic [7:0] e, input string tag);
        cmd(rcmd(a));
        repeat (3) @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        host_addr = 4'h4;
        -> smp;
        #0.2;
    endtask

    // monitor: compare data-out against the scoreboard
    initial begin
        forever begin
            @(smp);
            #0.1;
            while (exp_q.size() > 0) begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {24'b0, host_rdata[7:0]}, {24'b0, e});
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            ncheck++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", ncheck, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        peek(4'h0, v); chk("R1 cmd after reset", v, 32'h0);
        peek(4'h4, v); chk("R1 dout after reset", v, 32'h0);

        rd_int(7'd1, 8'hC3, "R7 default addr1");
        rd_int(7'd2, 8'hC3, "R7 default addr2");
        rd_int(7'd3, 8'h90, "R7 default addr3");
        rd_int(7'd4, 8'h98, "R7 default addr4");
        rd_int(7'd10, 8'h00, "R7 default addr10");

        // R5 settle timing: old value held two cycles, new on the third
        cmd(rcmd(7'd1));
        @(negedge clk); @(negedge clk);
        peek(4'h4, v); chk("R5 dout held before settle", v, 32'h0);
        peek(4'h0, v); chk("R2 read cmd readback", v, 32'h0000_0100);
        @(negedge clk);
        peek(4'h4, v); chk("R5 dout after settle", v, 32'h0000_00C3);

        // R3 busy window and commit
        cmd(wcmd(7'd10, 8'h5A));
        peek(4'h0, v); chk("R2 write cmd readback busy", v, 32'h0001_0A5A);
        repeat (3) @(negedge clk);
        peek(4'h0, v); chk("R3 busy in 4th cycle", {31'b0, v[16]}, 32'h1);
        @(negedge clk);
        peek(4'h0, v); chk("R3 busy cleared", v, 32'h0000_0A5A);
        rd_int(7'd10, 8'h5A, "R3 stored byte");

        // R4 command while busy is dropped
        cmd(wcmd(7'd11, 8'hA5));
        cmd(wcmd(7'd12, 8'h3C));
        peek(4'h0, v); chk("R4 latched cmd unchanged", v, 32'h0001_0BA5);
        repeat (4) @(negedge clk);
        rd_int(7'd12, 8'h00, "R4 dropped store");
        rd_int(7'd11, 8'hA5, "R4 first store kept");

        // R8 read-only status
        wr_int(7'd0, 8'hFF);
        rd_int(7'd0, 8'h00, "R8 status unchanged");

        // R9 holes and range
        wr_int(7'd5, 8'h77);
        rd_int(7'd5, 8'h00, "R9 hole 5");
        wr_int(7'd28, 8'h88);
        rd_int(7'd28, 8'h00, "R9 hole 28");
        wr_int(7'd40, 8'h99);
        rd_int(7'd40, 8'h00, "R9 out of range");
        wr_int(7'd35, 8'hE1);
        rd_int(7'd35, 8'hE1, "R3 last address");

        // R10 other offsets ignored
        @(negedge clk);
        host_wr = 1'b1; host_addr = 4'h4; host_wdata = wcmd(7'd12, 8'h11);
        @(negedge clk);
        host_addr = 4'h8;
        @(negedge clk);
        host_wr = 1'b0;
        repeat (5) @(negedge clk);
        peek(4'h0, v); chk("R10 cmd untouched", v, 32'h0000_2300);
        peek(4'h4, v); chk("R10 dout untouched", v, 32'h0000_00E1);
        rd_int(7'd12, 8'h00, "R10 no store");

        // R6 interrupt mirror
        codec_irq = 1'b1;
        peek(4'h4, v); chk("R6 irq high", v, 32'h0000_0100);
        codec_irq = 1'b0;
        peek(4'h4, v); chk("R6 irq low", v, 32'h0000_0000);

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", ncheck, nfail);
        $finish;
    end

endmodule